// File: doc/BRIEF.md
# UART Receive Character Queue with Flow Control

This block is the receive-side buffer of one serial channel. Finished characters arrive from the receiver's shift stage with their parity-error, framing-error and break flags. They are held in a byte queue of up to sixteen entries and handed to the processor through a read port. Each character keeps its own error flags from entry to exit, so the flags are always shown with the character at the head of the queue.

Two interrupt requests tell the processor when to read. A data request is raised while the fill is at or above a selectable trigger. A time-out request is raised when characters have waited below the trigger for four character times. A request-to-send output slows the far-end transmitter. It drops at a high-water mark and returns only at a lower low-water mark, and each trigger setting has its own pair of marks.

The input side is valid/ready. `in_ready` is high whenever a character can be stored. The shift stage cannot stall, so a character offered while `in_ready` is low is discarded and the overrun flag is set. The output side is also valid/ready: `out_valid` is high while the queue holds data, and a read happens on a cycle where `out_valid` and `out_ready` are both high. The control inputs are plain levels, except `fifo_reset` and `lsr_read`, which are one-cycle pulses.

Top module: `uart_rx_fifo_fc`

## Requirements
- R1: After reset the count is 0, `out_valid`, both interrupt requests and `overrun` are low, and `in_ready` and `rts` are high.
- R2: With `fifo_en` high the queue stores up to 16 characters and returns them in arrival order. Each character is shown on `out_data` together with its own `out_par_err`, `out_frm_err` and `out_brk`.
- R3: A character offered while the queue is full is discarded and the stored characters are unchanged. `overrun` is set and stays set until a `lsr_read` pulse clears it; if a new discard happens in the same cycle as the pulse, the flag stays set.
- R4: With `fifo_en` low the block acts as a single holding register: `in_ready` is low while one character is held, and a second character is discarded and sets `overrun`.
- R5: `trig_sel` selects the data trigger: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `irq_data` is high exactly while `count` is at or above the selected level. With `fifo_en` low the trigger is 1.
- R6: `rts` is registered and starts high. It goes low one cycle after the fill reaches the high-water mark: 4, 8, 12 or 14 for `trig_sel` 00, 01, 10 or 11.
- R7: Once low, `rts` returns high one cycle after the fill drains to the low-water mark or below: 1, 4, 8 or 10 for `trig_sel` 00, 01, 10 or 11.
- R8: With `fifo_en` high, `irq_timeout` rises when the queue has been non-empty and below the trigger for 40 `bit_tick` pulses. This is 4 characters of 10 bit times, counted with no write and no read in that span. It never rises while the fill is at or above the trigger.
- R9: Every accepted write and every read restarts the time-out count. A read clears `irq_timeout` and so does an empty queue; an accepted write does not clear it.
- R10: A `fifo_reset` pulse empties the queue in one cycle, clears the time-out count and `irq_timeout`, and sets `rts` high.
- R11: When a character is accepted and a read happens in the same cycle, the count does not change and the order of the characters is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Character offered by the shift stage |
| in_ready | output | 1 | Queue can store a character |
| in_data | input | 8 | Received character |
| in_par_err | input | 1 | Parity error of the offered character |
| in_frm_err | input | 1 | Framing error of the offered character |
| in_brk | input | 1 | Break condition of the offered character |
| out_valid | output | 1 | Queue holds at least one character |
| out_ready | input | 1 | Processor reads the head character |
| out_data | output | 8 | Head character |
| out_par_err | output | 1 | Parity error of the head character |
| out_frm_err | output | 1 | Framing error of the head character |
| out_brk | output | 1 | Break flag of the head character |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| trig_sel | input | 2 | Trigger select, encoded as in R5 |
| fifo_reset | input | 1 | Pulse that empties the queue |
| bit_tick | input | 1 | One pulse per bit time |
| lsr_read | input | 1 | Pulse that clears the overrun flag |
| count | output | 5 | Current fill |
| irq_data | output | 1 | Data trigger request |
| irq_timeout | output | 1 | Character time-out request |
| rts | output | 1 | Request to send, 1 = asserted |
| overrun | output | 1 | Sticky flag for a discarded character |

## Verification
A write and a read can land in the same cycle. The bench provokes this by raising `in_valid` and `out_ready` together on a partly filled queue. It then checks three things: the count is unchanged, the character taken was the old head, and the new character comes out last. A discarded write and a `lsr_read` pulse can also fall together. The bench offers a character to a full queue in the same cycle as the pulse and judges that `overrun` stays set, and that a later pulse on its own clears it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  // fill level that raises the data request
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // high-water mark: request-to-send drops here
  function automatic int unsigned rts_off_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4;
      2'b01:   return 8;
      2'b10:   return 12;
      default: return 14;
    endcase
  endfunction

  // low-water mark: request-to-send returns here
  function automatic int unsigned rts_on_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             cap_one,
  input  logic             push_req,
  input  rx_entry_t        push_entry,
  input  logic             pop_req,
  output rx_entry_t        head,
  output logic [CNT_W-1:0] count,
  output logic             can_take,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             drop
);
  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  // with cap_one any stored character fills the holding slot
  assign can_take = cap_one ? (count == '0) : (count != CNT_W'(DEPTH));
  assign push_ok  = push_req && can_take && !flush;
  assign drop     = push_req && !can_take;
  assign pop_ok   = pop_req && (count != '0) && !flush;
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rxq_level_ctl.sv
module rxq_level_ctl
  import rxq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] count,
  output logic             at_trigger,
  output logic             below_trigger,
  output logic             rts
);
  logic [CNT_W-1:0] trig, off_lvl, on_lvl;

  assign trig    = fifo_en ? CNT_W'(trig_level(trig_sel)) : CNT_W'(1);
  assign off_lvl = CNT_W'(rts_off_level(trig_sel));
  assign on_lvl  = CNT_W'(rts_on_level(trig_sel));

  assign at_trigger    = (count >= trig);
  assign below_trigger = (count != '0) && (count < trig);

  // hysteresis: drop at the high mark, return only at the low mark
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rts <= 1'b1;
    else if (flush)                   rts <= 1'b1;
    else if (rts && count >= off_lvl) rts <= 1'b0;
    else if (!rts && count <= on_lvl) rts <= 1'b1;
  end
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int unsigned LIMIT = 40,
  localparam int unsigned TW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic enable,
  input  logic nonempty,
  input  logic below_trigger,
  input  logic wr_evt,
  input  logic rd_evt,
  input  logic tick,
  output logic irq
);
  logic [TW-1:0] ticks;
  logic          expired;

  assign expired = (ticks == TW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        ticks <= '0;
    else if (flush || !enable || !nonempty || wr_evt || rd_evt) ticks <= '0;
    else if (tick && !expired)                         ticks <= ticks + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        irq <= 1'b0;
    else if (flush || !enable || !nonempty || rd_evt)  irq <= 1'b0;
    else if (expired && below_trigger)                 irq <= 1'b1;
  end
endmodule

// File: rtl/uart_rx_fifo_fc.sv
module uart_rx_fifo_fc
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH         = 16,
  parameter int unsigned BITS_PER_CHAR = 10,
  parameter int unsigned TO_CHARS      = 4,
  localparam int unsigned CNT_W        = $clog2(DEPTH + 1),
  localparam int unsigned TO_LIMIT     = BITS_PER_CHAR * TO_CHARS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_par_err,
  input  logic             in_frm_err,
  input  logic             in_brk,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_par_err,
  output logic             out_frm_err,
  output logic             out_brk,
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic             fifo_reset,
  input  logic             bit_tick,
  input  logic             lsr_read,
  output logic [CNT_W-1:0] count,
  output logic             irq_data,
  output logic             irq_timeout,
  output logic             rts,
  output logic             overrun
);
  rx_entry_t wr_entry, head;
  logic      push_ok, pop_ok, drop, below_trig, can_take;

  assign wr_entry = '{brk: in_brk, frm: in_frm_err, par: in_par_err, data: in_data};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (fifo_reset),
    .cap_one    (!fifo_en),
    .push_req   (in_valid),
    .push_entry (wr_entry),
    .pop_req    (out_ready),
    .head       (head),
    .count      (count),
    .can_take   (can_take),
    .push_ok    (push_ok),
    .pop_ok     (pop_ok),
    .drop       (drop)
  );

  rxq_level_ctl #(.CNT_W(CNT_W)) u_level (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (fifo_reset),
    .fifo_en       (fifo_en),
    .trig_sel      (trig_sel),
    .count         (count),
    .at_trigger    (irq_data),
    .below_trigger (below_trig),
    .rts           (rts)
  );

  rxq_timeout #(.LIMIT(TO_LIMIT)) u_tmo (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (fifo_reset),
    .enable        (fifo_en),
    .nonempty      (count != '0),
    .below_trigger (below_trig),
    .wr_evt        (push_ok),
    .rd_evt        (pop_ok),
    .tick          (bit_tick),
    .irq           (irq_timeout)
  );

  // a new discard wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        overrun <= 1'b0;
    else if (drop)     overrun <= 1'b1;
    else if (lsr_read) overrun <= 1'b0;
  end

  assign in_ready    = can_take;
  assign out_valid   = (count != '0);
  assign out_data    = head.data;
  assign out_par_err = head.par;
  assign out_frm_err = head.frm;
  assign out_brk     = head.brk;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             fifo_reset,
  input logic [1:0]       trig_sel,
  input logic [CNT_W-1:0] count,
  input logic             rts,
  input logic             irq_timeout,
  input logic             overrun
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !in_ready); // R3
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overrun); // R3
  AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts) |-> ($past(count) >= CNT_W'(rts_off_level($past(trig_sel))))); // R6
  AST_RTS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts) |-> ($past(fifo_reset) || $past(count) <= CNT_W'(rts_on_level($past(trig_sel))))); // R7
  AST_TMO_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_timeout |-> (count != '0)); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_reset |=> (count == '0 && !irq_timeout && rts)); // R10
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid && out_ready && !fifo_reset) |=> $stable(count)); // R11
endmodule

bind uart_rx_fifo_fc rxq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .fifo_reset  (fifo_reset),
  .trig_sel    (trig_sel),
  .count       (count),
  .rts         (rts),
  .irq_timeout (irq_timeout),
  .overrun     (overrun)
);

// File: tb/uart_rx_fifo_fc_test.sv
module uart_rx_fifo_fc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_par_err = 1'b0, in_frm_err = 1'b0, in_brk = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_ready = 1'b0, fifo_en = 1'b1, fifo_reset = 1'b0;
  logic       bit_tick = 1'b1, lsr_read = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic       in_ready, out_valid, out_par_err, out_frm_err, out_brk;
  logic       irq_data, irq_timeout, rts, overrun;
  logic [7:0] out_data;
  logic [4:0] count;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_rx_fifo_fc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_par_err(in_par_err), .in_frm_err(in_frm_err),
    .in_brk(in_brk), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_par_err(out_par_err), .out_frm_err(out_frm_err),
    .out_brk(out_brk), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .fifo_reset(fifo_reset), .bit_tick(bit_tick), .lsr_read(lsr_read),
    .count(count), .irq_data(irq_data), .irq_timeout(irq_timeout),
    .rts(rts), .overrun(overrun)
  );

  task automatic chk(input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] fl);
    in_valid = 1'b1; in_data = d; {in_brk, in_frm_err, in_par_err} = fl;
    @(negedge clk);
    in_valid = 1'b0; {in_brk, in_frm_err, in_par_err} = 3'b000;
  endtask

  task automatic pop(output logic [7:0] d, output logic [2:0] fl);
    d = out_data; fl = {out_brk, out_frm_err, out_par_err};
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic flush();
    fifo_reset = 1'b1; @(negedge clk); fifo_reset = 1'b0;
    lsr_read = 1'b1; @(negedge clk); lsr_read = 1'b0;
  endtask

  task automatic t_reset();
    chk(count, 0, "R1 count");
    chk(out_valid, 0, "R1 out_valid");
    chk(in_ready, 1, "R1 in_ready");
    chk(rts, 1, "R1 rts");
    chk(irq_data, 0, "R1 irq_data");
    chk(irq_timeout, 0, "R1 irq_timeout");
    chk(overrun, 0, "R1 overrun");
  endtask

  task automatic t_order();
    logic [7:0] d; logic [2:0] fl;
    flush(); trig_sel = 2'b11;
    push(8'hA1, 3'b001); push(8'hB2, 3'b010); push(8'hC3, 3'b100);
    chk(count, 3, "R2 count after 3");
    pop(d, fl); chk(d, 8'hA1, "R2 data 0"); chk(fl, 3'b001, "R2 parity flag");
    pop(d, fl); chk(d, 8'hB2, "R2 data 1"); chk(fl, 3'b010, "R2 framing flag");
    pop(d, fl); chk(d, 8'hC3, "R2 data 2"); chk(fl, 3'b100, "R2 break flag");
    chk(out_valid, 0, "R2 empty after drain");
  endtask

  task automatic t_full();
    logic [7:0] d; logic [2:0] fl;
    flush(); trig_sel = 2'b11;
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i), 3'b000);
    chk(count, 16, "R2 holds sixteen");
    chk(in_ready, 0, "R3 not ready when full");
    chk(overrun, 0, "R3 no overrun yet");
    push(8'hEE, 3'b111);
    chk(count, 16, "R3 count after drop");
    chk(overrun, 1, "R3 overrun set");
    in_valid = 1'b1; in_data = 8'hEF; lsr_read = 1'b1;
    @(negedge clk); in_valid = 1'b0; lsr_read = 1'b0;
    chk(overrun, 1, "R3 drop beats clear");
    lsr_read = 1'b1; @(negedge clk); lsr_read = 1'b0;
    chk(overrun, 0, "R3 cleared by lsr_read");
    for (int i = 0; i < 16; i++) begin
      pop(d, fl);
      chk(d, 8'h40 + i, "R3 stored data kept");
    end
  endtask

  task automatic t_trigger();
    for (int s = 0; s < 4; s++) begin
      int lv;
      lv = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      flush(); trig_sel = 2'(s);
      for (int i = 0; i < lv - 1; i++) push(8'(i), 3'b000);
      chk(irq_data, 0, "R5 below trigger");
      push(8'h55, 3'b000);
      chk(irq_data, 1, "R5 at trigger");
    end
  endtask

  task automatic t_rts();
    logic [7:0] d; logic [2:0] fl;
    for (int s = 0; s < 4; s++) begin
      int off, on;
      off = (s == 0) ? 4 : (s == 1) ? 8 : (s == 2) ? 12 : 14;
      on  = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 10;
      flush(); trig_sel = 2'(s);
      for (int i = 0; i < off - 1; i++) push(8'(i), 3'b000);
      idle(1); chk(rts, 1, "R6 rts held below high mark");
      push(8'h77, 3'b000); idle(1);
      chk(rts, 0, "R6 rts dropped at high mark");
      for (int i = 0; i < off - on - 1; i++) pop(d, fl);
      idle(1); chk(rts, 0, "R7 rts stays low above low mark");
      pop(d, fl); idle(1);
      chk(rts, 1, "R7 rts back at low mark");
    end
  endtask

  task automatic t_timeout();
    logic [7:0] d; logic [2:0] fl;
    flush(); trig_sel = 2'b01;
    push(8'h01, 3'b000); push(8'h02, 3'b000);
    idle(10); chk(irq_timeout, 0, "R8 no time-out early");
    idle(50); chk(irq_timeout, 1, "R8 time-out below trigger");
    push(8'h03, 3'b000);
    chk(irq_timeout, 1, "R9 write keeps time-out");
    idle(10); chk(irq_timeout, 1, "R9 still set after write");
    pop(d, fl); chk(irq_timeout, 0, "R9 read clears time-out");
    idle(20); chk(irq_timeout, 0, "R9 restarted count not expired");
    idle(40); chk(irq_timeout, 1, "R8 expires again");
    pop(d, fl); pop(d, fl);
    idle(60); chk(irq_timeout, 0, "R9 empty queue no time-out");
    for (int i = 0; i < 4; i++) push(8'(i), 3'b000);
    idle(60); chk(irq_timeout, 0, "R8 none at trigger");
  endtask

  task automatic t_nonfifo();
    logic [7:0] d; logic [2:0] fl;
    flush(); fifo_en = 1'b0; trig_sel = 2'b11;
    push(8'h5A, 3'b000);
    chk(count, 1, "R4 one held");
    chk(in_ready, 0, "R4 not ready with one held");
    chk(irq_data, 1, "R5 trigger 1 without queue");
    push(8'hA5, 3'b000);
    chk(overrun, 1, "R4 second char overruns");
    pop(d, fl); chk(d, 8'h5A, "R4 first char kept");
    chk(count, 0, "R4 empty after read");
    fifo_en = 1'b1;
  endtask

  task automatic t_flush();
    flush(); trig_sel = 2'b00;
    for (int i = 0; i < 10; i++) push(8'(i), 3'b000);
    idle(1); chk(rts, 0, "R10 rts low before reset");
    fifo_reset = 1'b1; @(negedge clk); fifo_reset = 1'b0;
    chk(count, 0, "R10 emptied");
    chk(out_valid, 0, "R10 no data");
    chk(rts, 1, "R10 rts asserted");
  endtask

  task automatic t_pushpop();
    logic [7:0] d; logic [2:0] fl;
    flush(); trig_sel = 2'b11;
    push(8'h10, 3'b000); push(8'h11, 3'b000); push(8'h12, 3'b000);
    d = out_data;
    in_valid = 1'b1; in_data = 8'h13; out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b0;
    chk(d, 8'h10, "R11 old head taken");
    chk(count, 3, "R11 count unchanged");
    pop(d, fl); chk(d, 8'h11, "R11 order 1");
    pop(d, fl); chk(d, 8'h12, "R11 order 2");
    pop(d, fl); chk(d, 8'h13, "R11 new char last");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_full();
    t_trigger();
    t_rts();
    t_timeout();
    t_nonfifo();
    t_flush();
    t_pushpop();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule